// File: doc/BRIEF.md
# Direction-Adaptive Stream Prefetch Generator

This block sits beside the read-request path of a secondary-cache prefetch buffer. For every read request it receives, it produces in the same cycle the address of one neighbouring cache line to prefetch. A line is 32 bytes, so all address work happens on the 35-bit line number taken from a 40-bit byte address. The five offset bits of the request are ignored.

The block keeps the line numbers of the two most recent requests. It checks each new request against them. A request one line above a remembered line counts as an ascending step. A request one line below counts as a descending step. Two saturating counters collect these steps. The block starts out ascending and issues the next higher line. Two descending steps switch it to issuing the next lower line, and two ascending steps switch it back. The output multiplexer is steered only by registered direction state, so choosing the direction adds no delay to the request path.

Top module: `stream_pf_gen`

## Requirements
- R1: Addresses are handled at line granularity. The low 5 bits of `req_addr` have no effect on any output or state, and the low 5 bits of `pf_addr` are always zero.
- R2: While the direction is ascending (the state after reset), `pf_addr` equals the request's line number plus one, shifted left by 5. It is valid in the same cycle as the request.
- R3: `pf_valid` is never high in a cycle where `req_valid` is low.
- R4: The history holds the line numbers of the last two accepted requests, first in, first out. A new request is compared against both of them. A line pushed three requests earlier no longer produces a match.
- R5: A request whose line equals a remembered line minus one adds one to the descending counter. When that counter reaches 2 while the direction is ascending, the direction becomes descending. From the next request on, `pf_addr` is the line number minus one, shifted left by 5.
- R6: A request whose line equals a remembered line plus one adds one to the ascending counter. When that counter reaches 2 while the direction is descending, the direction returns to ascending from the next request on.
- R7: Both 2-bit counters saturate at 3 and are cleared whenever the direction changes. Matches collected before a switch therefore never count toward the next switch.
- R8: Direction and counters change only on an accepted request that matches a neighbour relation. Idle cycles and non-matching requests leave them unchanged, but a non-matching request is still pushed into the history.
- R9: No prefetch is issued when the step would wrap. An ascending request for the highest line, or a descending request for line 0, gives `pf_valid` low.
- R10: Asserting `rst_n` low clears both history entries and marks them invalid, zeroes both counters and sets the direction to ascending. Lines seen before the reset produce no matches after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | A read request is present this cycle |
| req_addr | input | 40 | Byte address of the request |
| pf_valid | output | 1 | A prefetch address is issued this cycle |
| pf_addr | output | 40 | Line-aligned byte address to prefetch |

## Verification
The bound checker watches, on every cycle, the properties that hold cycle by cycle. These are: a prefetch only accompanies a request, the output is line aligned and one line away in the registered direction, the wrap boundaries are suppressed, idle cycles leave the direction and counters untouched, a direction change leaves both counters cleared, and reset returns the block to ascending. Other behaviour builds up over a run of requests. This covers the depth of the history, the two-match switching threshold, the fact that matches before a switch are discarded, and the loss of history across a reset. Only the bench's request sequences can show it, so the bench compares every cycle against a behavioural model driven through directed and random streams.

// File: rtl/stream_pf_pkg.sv
package stream_pf_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } pf_dir_e;
endpackage

// File: rtl/spf_history.sv
// Shift-register history of recent request line numbers, newest in slot 0.
module spf_history #(
  parameter int LINE_W = 35,
  parameter int DEPTH  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [LINE_W-1:0]             line_in,
  output logic [DEPTH-1:0][LINE_W-1:0]  ent,
  output logic [DEPTH-1:0]              ent_vld
);
  logic [DEPTH-1:0][LINE_W-1:0] ent_nx;
  logic [DEPTH-1:0]             vld_nx;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      if (g == 0) begin : g_head
        always_comb begin
          ent_nx[g] = ent[g];
          vld_nx[g] = ent_vld[g];
          if (push) begin
            ent_nx[g] = line_in;
            vld_nx[g] = 1'b1;
          end
        end
      end else begin : g_tail
        always_comb begin
          ent_nx[g] = ent[g];
          vld_nx[g] = ent_vld[g];
          if (push) begin
            ent_nx[g] = ent[g-1];
            vld_nx[g] = ent_vld[g-1];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent[g]     <= '0;
          ent_vld[g] <= 1'b0;
        end else if (push) begin
          ent[g]     <= ent_nx[g];
          ent_vld[g] <= vld_nx[g];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/spf_match.sv
// Compares the incoming line with every valid history slot.
module spf_match #(
  parameter int LINE_W = 35,
  parameter int DEPTH  = 2
) (
  input  logic [LINE_W-1:0]             line,
  input  logic [LINE_W-1:0]             line_inc,
  input  logic [LINE_W-1:0]             line_dec,
  input  logic                          at_max,
  input  logic                          at_min,
  input  logic [DEPTH-1:0][LINE_W-1:0]  ent,
  input  logic [DEPTH-1:0]              ent_vld,
  output logic                          up_hit,
  output logic                          dn_hit
);
  logic [DEPTH-1:0] up_vec;
  logic [DEPTH-1:0] dn_vec;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      // ascending step: the stored line sits one below the new one
      assign up_vec[g] = ent_vld[g] && !at_min && (ent[g] == line_dec);
      // descending step: the stored line sits one above the new one
      assign dn_vec[g] = ent_vld[g] && !at_max && (ent[g] == line_inc);
    end
  endgenerate

  logic unused_line;
  assign unused_line = ^line;

  assign up_hit = |up_vec;
  assign dn_hit = |dn_vec;
endmodule

// File: rtl/spf_dir_ctrl.sv
// Saturating up/down step counters and the registered stream direction.
module spf_dir_ctrl
  import stream_pf_pkg::*;
#(
  parameter int CNT_W     = 2,
  parameter int SWITCH_AT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             up_hit,
  input  logic             dn_hit,
  output pf_dir_e          dir,
  output logic [CNT_W-1:0] up_cnt,
  output logic [CNT_W-1:0] dn_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_THR = CNT_W'(SWITCH_AT);

  logic [CNT_W-1:0] up_inc, dn_inc;
  logic [CNT_W-1:0] up_nx, dn_nx;
  pf_dir_e          dir_nx;

  always_comb begin
    up_inc = (up_hit && up_cnt != CNT_MAX) ? up_cnt + CNT_W'(1) : up_cnt;
    dn_inc = (dn_hit && dn_cnt != CNT_MAX) ? dn_cnt + CNT_W'(1) : dn_cnt;
    up_nx  = up_inc;
    dn_nx  = dn_inc;
    dir_nx = dir;
    if (dir == DIR_UP && dn_inc >= CNT_THR) begin
      dir_nx = DIR_DOWN;
      up_nx  = '0;
      dn_nx  = '0;
    end else if (dir == DIR_DOWN && up_inc >= CNT_THR) begin
      dir_nx = DIR_UP;
      up_nx  = '0;
      dn_nx  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir    <= DIR_UP;
      up_cnt <= '0;
      dn_cnt <= '0;
    end else if (upd) begin
      dir    <= dir_nx;
      up_cnt <= up_nx;
      dn_cnt <= dn_nx;
    end
  end
endmodule

// File: rtl/stream_pf_gen.sv
module stream_pf_gen
  import stream_pf_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 32,
  parameter int HIST_DEPTH = 2,
  parameter int CNT_W      = 2,
  parameter int SWITCH_AT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFS_W;

  logic [LINE_W-1:0] line, line_inc, line_dec, pf_line;
  logic              at_max, at_min;
  logic [HIST_DEPTH-1:0][LINE_W-1:0] hist_ent;
  logic [HIST_DEPTH-1:0]             hist_vld;
  logic              up_hit, dn_hit;
  pf_dir_e           dir;
  logic [CNT_W-1:0]  up_cnt, dn_cnt;
  logic              dir_down;

  logic unused_ofs;
  assign unused_ofs = ^req_addr[OFS_W-1:0];

  assign line     = req_addr[ADDR_W-1:OFS_W];
  assign line_inc = line + LINE_W'(1);
  assign line_dec = line - LINE_W'(1);
  assign at_max   = &line;
  assign at_min   = ~|line;
  assign dir_down = (dir == DIR_DOWN);

  spf_history #(.LINE_W(LINE_W), .DEPTH(HIST_DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(req_valid), .line_in(line),
    .ent(hist_ent), .ent_vld(hist_vld)
  );

  spf_match #(.LINE_W(LINE_W), .DEPTH(HIST_DEPTH)) u_match (
    .line(line), .line_inc(line_inc), .line_dec(line_dec),
    .at_max(at_max), .at_min(at_min),
    .ent(hist_ent), .ent_vld(hist_vld),
    .up_hit(up_hit), .dn_hit(dn_hit)
  );

  spf_dir_ctrl #(.CNT_W(CNT_W), .SWITCH_AT(SWITCH_AT)) u_dir (
    .clk(clk), .rst_n(rst_n), .upd(req_valid),
    .up_hit(up_hit), .dn_hit(dn_hit),
    .dir(dir), .up_cnt(up_cnt), .dn_cnt(dn_cnt)
  );

  // output mux steered only by registered direction
  always_comb begin
    if (dir_down) begin
      pf_line  = line_dec;
      pf_valid = req_valid && !at_min;
    end else begin
      pf_line  = line_inc;
      pf_valid = req_valid && !at_max;
    end
  end

  assign pf_addr = {pf_line, {OFS_W{1'b0}}};
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int ADDR_W = 40,
  parameter int OFS_W  = 5,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              dir_down,
  input logic [CNT_W-1:0]  up_cnt,
  input logic [CNT_W-1:0]  dn_cnt
);
  localparam int LW = ADDR_W - OFS_W;
  logic [LW-1:0] rq_line, pf_line;
  assign rq_line = req_addr[ADDR_W-1:OFS_W];
  assign pf_line = pf_addr[ADDR_W-1:OFS_W];

  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_addr[OFS_W-1:0] == '0);

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !dir_down) |-> pf_line == rq_line + LW'(1));

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && dir_down) |-> pf_line == rq_line - LW'(1));

  assert_pf_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !pf_valid);

  assert_switch_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_down) |-> (up_cnt == '0 && dn_cnt == '0));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(dir_down) && $stable(up_cnt) && $stable(dn_cnt)));

  assert_no_wrap_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dir_down && (&rq_line)) |-> !pf_valid);

  assert_no_wrap_bottom_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dir_down && !(|rq_line)) |-> !pf_valid);

  assert_reset_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dir_down && up_cnt == '0 && dn_cnt == '0));
endmodule

bind stream_pf_gen spf_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .pf_valid(pf_valid), .pf_addr(pf_addr), .dir_down(dir_down),
  .up_cnt(up_cnt), .dn_cnt(dn_cnt)
);

// File: tb/stream_pf_gen_bench.sv
module stream_pf_gen_bench;
  localparam int AW = 40;
  localparam int OW = 5;
  localparam int LW = AW - OW;
  localparam logic [LW-1:0] LMAX = {LW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          pf_valid;
  logic [AW-1:0] pf_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  logic [LW-1:0] hq[$];
  int  m_up, m_dn;
  bit  m_desc;

  always #5 clk = ~clk;

  stream_pf_gen u_stream_pf_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic model_reset();
    hq.delete();
    m_up = 0; m_dn = 0; m_desc = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic v, input logic [AW-1:0] a, input string tag);
    logic [LW-1:0] ln;
    logic          ev;
    logic [AW-1:0] ea;
    bit uh, dh;
    @(negedge clk);
    req_valid = v; req_addr = a;
    #1;
    ln = a[AW-1:OW];
    if (m_desc) begin ev = v && (ln != '0); ea = {ln - LW'(1), {OW{1'b0}}}; end
    else        begin ev = v && (ln != LMAX); ea = {ln + LW'(1), {OW{1'b0}}}; end
    checks++;
    if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
      fails++;
      $display("FAIL %s: pf_valid=%0b pf_addr=%h expected pf_valid=%0b pf_addr=%h",
               tag, pf_valid, pf_addr, ev, ea);
    end
    if (v) begin
      uh = 0; dh = 0;
      foreach (hq[i]) begin
        if (ln != '0 && hq[i] == ln - LW'(1)) uh = 1;
        if (ln != LMAX && hq[i] == ln + LW'(1)) dh = 1;
      end
      if (uh && m_up < 3) m_up++;
      if (dh && m_dn < 3) m_dn++;
      if (!m_desc && m_dn >= 2) begin m_desc = 1; m_up = 0; m_dn = 0; end
      else if (m_desc && m_up >= 2) begin m_desc = 0; m_up = 0; m_dn = 0; end
      hq.push_front(ln);
      if (hq.size() > 2) void'(hq.pop_back());
    end
  endtask

  function automatic logic [AW-1:0] la(input logic [LW-1:0] l, input int ofs);
    return {l, OW'(ofs)};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin : main
    model_reset();
    do_reset();
    // reset state: idle gives no prefetch
    step(1'b0, '0, "R3");
    step(1'b0, la(35'd50, 3), "R3");
    // ascending run with varying offsets
    step(1'b1, la(35'd100, 0),  "R2");
    step(1'b1, la(35'd101, 7),  "R1");
    step(1'b1, la(35'd101, 31), "R1");
    step(1'b1, la(35'd102, 12), "R2");
    step(1'b0, la(35'd999, 0),  "R8");
    // descending run: two down matches switch
    step(1'b1, la(35'd200, 0), "R5");
    step(1'b1, la(35'd199, 4), "R5");
    step(1'b1, la(35'd198, 0), "R5");
    step(1'b1, la(35'd197, 0), "R5");
    step(1'b1, la(35'd196, 9), "R5");
    // stale ascending matches were cleared: one up match does not flip
    step(1'b1, la(35'd600, 0), "R7");
    step(1'b1, la(35'd601, 0), "R7");
    step(1'b1, la(35'd900, 0), "R7");
    // non-matching request pushed, then matched from history slot 1
    step(1'b1, la(35'd5000, 0), "R8");
    step(1'b1, la(35'd7000, 0), "R8");
    step(1'b1, la(35'd5001, 0), "R4");
    step(1'b1, la(35'd8000, 0), "R6");
    // now ascending again
    step(1'b1, la(35'd8100, 0), "R6");
    // depth two: line three back is forgotten
    step(1'b1, la(35'd300, 0), "R4");
    step(1'b1, la(35'd400, 0), "R4");
    step(1'b1, la(35'd500, 0), "R4");
    step(1'b1, la(35'd299, 0), "R4");
    step(1'b1, la(35'd700, 0), "R4");
    step(1'b1, la(35'd699, 0), "R4");
    step(1'b1, la(35'd1000, 0), "R4");
    // wrap at the top while ascending
    step(1'b1, la(LMAX, 5), "R9");
    step(1'b1, la(LMAX - 35'd1, 0), "R9");
    step(1'b1, la(LMAX - 35'd2, 0), "R9");
    step(1'b1, la(35'd2, 0), "R9");
    step(1'b1, la(35'd1, 0), "R9");
    step(1'b1, la(35'd0, 0), "R9");
    step(1'b1, la(35'd0, 17), "R9");
    // reset mid-stream: back to ascending, history gone
    step(1'b1, la(35'd41, 0), "R10");
    step(1'b1, la(35'd40, 0), "R10");
    do_reset();
    step(1'b1, la(35'd39, 0), "R10");
    step(1'b1, la(35'd100, 0), "R10");
    step(1'b1, la(35'd38, 0), "R10");
    // random neighbourhood walk
    begin
      logic [LW-1:0] cur;
      cur = LW'(32'h4000);
      for (int k = 0; k < 2000; k++) begin
        int r;
        r = int'($urandom_range(0, 9));
        case (r)
          0, 1, 2: cur = cur + LW'(1);
          3, 4, 5: cur = cur - LW'(1);
          6:       cur = cur + LW'(2);
          7:       cur = LW'($urandom_range(0, 65535));
          default: ;
        endcase
        step(($urandom_range(0, 4) != 0), la(cur, int'($urandom_range(0, 31))), "R8");
      end
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule